// File: doc/BRIEF.md
# Configurable Feedback Input Channel

This block takes one asynchronous digital feedback signal from a pad, brings it into the clock domain, and turns it into drive controls for a receive pin. A small register bank sets the behaviour. Software can invert the signal on its way to the pin. The pin can be driven push-pull or used as open-drain. A weak pull current on the input can be enabled and pointed up or down. Software can also ask to be told about any change at the input.

The raw synchronized input level can be read back at any time, whatever the polarity setting. When change detection is on, every edge at the input sets a sticky flag. The flag shows on an active-low diagnostic pin and is cleared when software reads it. The pad drivers and the analog pull sources are outside the block. They appear here only as enable and direction signals.

Registers are reached through plain single-cycle read and write strobes with an address and data. Read data is registered and appears on the cycle after the strobe.

Top module: `fbk_chan`

## Requirements
- R1: A read of address 0x00 returns the synchronized input level in bit 7 (1 = high) and 0 in bits 6..0, whatever the polarity setting. The input reaches this bit at the second rising clock edge after the edge that first samples it.
- R2: The logical receive level is the synchronized input XOR the polarity bit (address 0x01 bit 2, reset 0). With polarity 0 a high input gives a high level, and with polarity 1 a high input gives a low level.
- R3: With the mode bit (address 0x01 bit 0, reset 0) at 0, the output is push-pull: rx_hi_drv equals the logical level and rx_lo_drv is its inverse.
- R4: With the mode bit at 1, the output is open-drain: rx_hi_drv is 0 and rx_lo_drv (the transistor) is on exactly when the logical level is 1. rx_hi_drv and rx_lo_drv are never both 1.
- R5: The pull enable bit (address 0x01 bit 3) resets to 1. While it is 0, pull_en is 0.
- R6: pull_up equals the polarity bit XOR the invert-pull bit (address 0x01 bit 4, reset 0). A value of 0 means pull-down and 1 means pull-up.
- R7: With the change enable bit (address 0x02 bit 7, reset 0) at 1, a rising or a falling input change sets the sticky flag (address 0x02 bit 6) at the rising edge after the synchronized level changes. diag_n is 0 exactly while the flag is set.
- R8: A read of address 0x02 returns the flag and then clears it. If a change event falls in the same cycle as the read, the flag stays set.
- R9: With the change enable bit at 0, input changes leave the flag and diag_n unchanged.
- R10: Writes to read-only bits are ignored: all of address 0x00, and bit 6 of address 0x02. Unused bits and unmapped addresses read as 0.
- R11: rdata is registered. It updates at the edge that samples rd_en and holds its value otherwise. After reset, address 0x01 reads 0x08 and address 0x02 reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fb_in | input | 1 | Asynchronous feedback input from the pad |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Register address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data |
| rx_hi_drv | output | 1 | High-side driver enable for the receive pin |
| rx_lo_drv | output | 1 | Low-side driver enable for the receive pin |
| pull_en | output | 1 | Weak pull current enable |
| pull_up | output | 1 | Pull direction: 1 up, 0 down |
| diag_n | output | 1 | Active-low diagnostic, low while the change flag is set |

## Verification
A wrong synchronizer or polarity state shows up on the two driver enables within two edges of an input change. It also shows at bit 7 of the status read on the next read. A stuck or lost change flag shows on diag_n at the edge after the synchronized change, and it shows again in the value returned by the clear-on-read access. A bad configuration bit becomes visible on the drive and pull pins in the same cycle as the write. The bench compares every output against a behavioural model on every cycle, so any such divergence is caught within one cycle of the point where it reaches a port.

// File: rtl/fbk_chan_pkg.sv
package fbk_chan_pkg;

  // register addresses
  localparam int ADR_STAT = 0;
  localparam int ADR_CFG  = 1;
  localparam int ADR_CHG  = 2;

  // bit positions
  localparam int B_STAT_LVL = 7;
  localparam int B_CFG_OD   = 0;
  localparam int B_CFG_POL  = 2;
  localparam int B_CFG_PEN  = 3;
  localparam int B_CFG_INV  = 4;
  localparam int B_CHG_EN   = 7;
  localparam int B_CHG_FLAG = 6;

  typedef struct packed {
    logic inv_pull;
    logic pull_en;
    logic pol;
    logic od;
  } cfg_t;

  localparam cfg_t CFG_RST = '{inv_pull: 1'b0, pull_en: 1'b1, pol: 1'b0, od: 1'b0};

endpackage

// File: rtl/fbk_rst_sync.sv
module fbk_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/fbk_in_sync.sv
module fbk_in_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic lvl,
  output logic chg
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              prev_q;
  logic              prev_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], din};
    prev_d = sync_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  assign lvl = sync_q[STAGES-1];
  assign chg = sync_q[STAGES-1] ^ prev_q;
endmodule

// File: rtl/fbk_regs.sv
module fbk_regs
  import fbk_chan_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              lvl,
  input  logic              chg,
  output cfg_t              cfg,
  output logic              cd_en,
  output logic              flag,
  output logic [DATA_W-1:0] rdata
);
  logic sel_stat, sel_cfg, sel_chg;
  logic cfg_we, cden_we, flag_we, rd_we;
  logic set_ev, clr_ev;

  cfg_t              cfg_q, cfg_d;
  logic              cden_q, cden_d;
  logic              flag_q, flag_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;

  always_comb begin
    sel_stat = (addr == ADDR_W'(ADR_STAT));
    sel_cfg  = (addr == ADDR_W'(ADR_CFG));
    sel_chg  = (addr == ADDR_W'(ADR_CHG));

    cfg_we   = wr_en & sel_cfg;
    cden_we  = wr_en & sel_chg;
    rd_we    = rd_en;

    set_ev   = cden_q & chg;
    clr_ev   = rd_en & sel_chg;
    flag_we  = set_ev | clr_ev;

    cfg_d.od       = wdata[B_CFG_OD];
    cfg_d.pol      = wdata[B_CFG_POL];
    cfg_d.pull_en  = wdata[B_CFG_PEN];
    cfg_d.inv_pull = wdata[B_CFG_INV];
    cden_d         = wdata[B_CHG_EN];
    flag_d         = set_ev;

    rdata_d = '0;
    if (sel_stat) begin
      rdata_d[B_STAT_LVL] = lvl;
    end else if (sel_cfg) begin
      rdata_d[B_CFG_OD]  = cfg_q.od;
      rdata_d[B_CFG_POL] = cfg_q.pol;
      rdata_d[B_CFG_PEN] = cfg_q.pull_en;
      rdata_d[B_CFG_INV] = cfg_q.inv_pull;
    end else if (sel_chg) begin
      rdata_d[B_CHG_EN]   = cden_q;
      rdata_d[B_CHG_FLAG] = flag_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= CFG_RST;
    end else if (cfg_we) begin
      cfg_q <= cfg_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cden_q <= 1'b0;
    end else if (cden_we) begin
      cden_q <= cden_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (flag_we) begin
      flag_q <= flag_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (rd_we) begin
      rdata_q <= rdata_d;
    end
  end

  assign cfg   = cfg_q;
  assign cd_en = cden_q;
  assign flag  = flag_q;
  assign rdata = rdata_q;
endmodule

// File: rtl/fbk_drive.sv
module fbk_drive
  import fbk_chan_pkg::*;
(
  input  logic lvl,
  input  cfg_t cfg,
  output logic hi_drv,
  output logic lo_drv,
  output logic pull_en,
  output logic pull_up
);
  logic rx_level;

  always_comb begin
    rx_level = lvl ^ cfg.pol;
    if (cfg.od) begin
      hi_drv = 1'b0;
      lo_drv = rx_level;
    end else begin
      hi_drv = rx_level;
      lo_drv = ~rx_level;
    end
    pull_en = cfg.pull_en;
    pull_up = cfg.pol ^ cfg.inv_pull;
  end
endmodule

// File: rtl/fbk_chan.sv
module fbk_chan
  import fbk_chan_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fb_in,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rx_hi_drv,
  output logic              rx_lo_drv,
  output logic              pull_en,
  output logic              pull_up,
  output logic              diag_n
);
  logic rst_int_n;
  logic lvl;
  logic chg;
  logic cd_en;
  logic flag;
  cfg_t cfg;

  fbk_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  fbk_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .din   (fb_in),
    .lvl   (lvl),
    .chg   (chg)
  );

  fbk_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk   (clk),
    .rst_n (rst_int_n),
    .wr_en (wr_en),
    .rd_en (rd_en),
    .addr  (addr),
    .wdata (wdata),
    .lvl   (lvl),
    .chg   (chg),
    .cfg   (cfg),
    .cd_en (cd_en),
    .flag  (flag),
    .rdata (rdata)
  );

  fbk_drive u_drv (
    .lvl     (lvl),
    .cfg     (cfg),
    .hi_drv  (rx_hi_drv),
    .lo_drv  (rx_lo_drv),
    .pull_en (pull_en),
    .pull_up (pull_up)
  );

  assign diag_n = ~flag;
endmodule

// File: rtl/fbk_chan_chk.sv
module fbk_chan_chk
  import fbk_chan_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_ni,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] rdata,
  input logic              rx_hi_drv,
  input logic              rx_lo_drv,
  input logic              cfg_od,
  input logic              lvl,
  input logic              chg,
  input logic              cd_en,
  input logic              diag_n
);
  AST_DRV_EXCL: assert property (@(posedge clk) disable iff (!rst_ni)
    !(rx_hi_drv && rx_lo_drv)); // R4

  AST_OD_NO_SOURCE: assert property (@(posedge clk) disable iff (!rst_ni)
    cfg_od |-> !rx_hi_drv); // R4

  AST_CHG_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_ni)
    (cd_en && chg) |=> !diag_n); // R7

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_ni)
    (rd_en && addr == ADDR_W'(ADR_CHG) && !(cd_en && chg)) |=> diag_n); // R8

  AST_NO_SPURIOUS_FLAG: assert property (@(posedge clk) disable iff (!rst_ni)
    (diag_n && !(cd_en && chg)) |=> diag_n); // R9

  AST_STATUS_READ: assert property (@(posedge clk) disable iff (!rst_ni)
    (rd_en && addr == ADDR_W'(ADR_STAT)) |=> (rdata == (DATA_W'($past(lvl)) << B_STAT_LVL))); // R1

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_ni)
    !rd_en |=> $stable(rdata)); // R11
endmodule

bind fbk_chan fbk_chan_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_ni    (rst_int_n),
  .rd_en     (rd_en),
  .addr      (addr),
  .rdata     (rdata),
  .rx_hi_drv (rx_hi_drv),
  .rx_lo_drv (rx_lo_drv),
  .cfg_od    (cfg.od),
  .lvl       (lvl),
  .chg       (chg),
  .cd_en     (cd_en),
  .diag_n    (diag_n)
);

// File: tb/fbk_chan_test.sv
module fbk_chan_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       fb_in;
  logic       wr_en;
  logic       rd_en;
  logic [7:0] addr;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic       rx_hi_drv, rx_lo_drv, pull_en, pull_up, diag_n;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;
  bit model_on = 0;

  always #10 clk = ~clk;

  fbk_chan uut (
    .clk(clk), .rst_n(rst_n), .fb_in(fb_in), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .rx_hi_drv(rx_hi_drv),
    .rx_lo_drv(rx_lo_drv), .pull_en(pull_en), .pull_up(pull_up), .diag_n(diag_n)
  );

  // behavioural reference model
  logic       hist[$];
  logic       m_od = 0, m_pol = 0, m_pen = 1, m_inv = 0, m_cden = 0, m_flag = 0;
  logic [7:0] m_rdata = 0;

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%02h expected=%02h at t=%0t", tag, got, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (model_on) begin
      logic ev, lv;
      lv = hist[1];
      ev = (hist[1] != hist[0]);
      if (rd_en) begin
        case (addr)
          8'h00:   m_rdata = {lv, 7'b0};
          8'h01:   m_rdata = {3'b0, m_inv, m_pen, m_pol, 1'b0, m_od};
          8'h02:   m_rdata = {m_cden, m_flag, 6'b0};
          default: m_rdata = 8'h00;
        endcase
      end
      if (m_cden && ev) m_flag = 1'b1;
      else if (rd_en && addr == 8'h02) m_flag = 1'b0;
      if (wr_en && addr == 8'h01) begin
        m_od = wdata[0]; m_pol = wdata[2]; m_pen = wdata[3]; m_inv = wdata[4];
      end
      if (wr_en && addr == 8'h02) m_cden = wdata[7];
      hist.push_back(fb_in);
      void'(hist.pop_front());
    end
  end

  always @(negedge clk) begin
    if (model_on && !done) begin
      logic rl;
      rl = hist[1] ^ m_pol;
      chk("R11 rdata model", rdata, m_rdata);
      chk("R3/R4 hi_drv model", {7'b0, rx_hi_drv}, {7'b0, (m_od ? 1'b0 : rl)});
      chk("R3/R4 lo_drv model", {7'b0, rx_lo_drv}, {7'b0, (m_od ? rl : ~rl)});
      chk("R5 pull_en model", {7'b0, pull_en}, {7'b0, m_pen});
      chk("R6 pull_up model", {7'b0, pull_up}, {7'b0, m_pol ^ m_inv});
      chk("R7 diag_n model", {7'b0, diag_n}, {7'b0, ~m_flag});
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog (all requirements) got=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0; d = rdata;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [7:0] d;
    hist = '{1'b0, 1'b0, 1'b0};
    rst_n = 0; fb_in = 0; wr_en = 0; rd_en = 0; addr = 0; wdata = 0;
    settle(4);
    rst_n = 1;
    settle(4);
    model_on = 1;

    // reset state
    rd(8'h01, d); chk("R11 cfg reset", d, 8'h08);
    rd(8'h02, d); chk("R11 chg reset", d, 8'h00);
    chk("R5 pull_en reset", {7'b0, pull_en}, 8'h01);
    chk("R6 pull_up reset", {7'b0, pull_up}, 8'h00);
    chk("R3 lo_drv idle", {7'b0, rx_lo_drv}, 8'h01);

    // status and push-pull polarity
    fb_in = 1; settle(3);
    rd(8'h00, d); chk("R1 status high", d, 8'h80);
    chk("R2 R3 hi_drv pol0", {7'b0, rx_hi_drv}, 8'h01);
    wr(8'h01, 8'h0C);
    chk("R2 hi_drv pol1", {7'b0, rx_hi_drv}, 8'h00);
    chk("R2 lo_drv pol1", {7'b0, rx_lo_drv}, 8'h01);
    chk("R6 pull_up pol1", {7'b0, pull_up}, 8'h01);
    rd(8'h00, d); chk("R1 status ignores pol", d, 8'h80);

    // open-drain
    wr(8'h01, 8'h1D);
    chk("R4 od off", {7'b0, rx_lo_drv}, 8'h00);
    chk("R6 pull_up inv", {7'b0, pull_up}, 8'h00);
    fb_in = 0; settle(3);
    chk("R4 od on", {7'b0, rx_lo_drv}, 8'h01);
    chk("R4 od no high", {7'b0, rx_hi_drv}, 8'h00);

    // pull disable, unused bits
    wr(8'h01, 8'h14);
    chk("R5 pull off", {7'b0, pull_en}, 8'h00);
    rd(8'h01, d); chk("R11 cfg read", d, 8'h14);
    wr(8'h01, 8'hFF);
    rd(8'h01, d); chk("R10 unused cfg bits", d, 8'h1D);
    wr(8'h01, 8'h08);

    // status not writable, unmapped reads zero
    wr(8'h00, 8'hFF);
    rd(8'h00, d); chk("R10 status write ignored", d, 8'h00);
    rd(8'h05, d); chk("R10 unmapped", d, 8'h00);

    // change detect disabled
    fb_in = 1; settle(4);
    chk("R9 no flag diag", {7'b0, diag_n}, 8'h01);
    rd(8'h02, d); chk("R9 no flag read", d, 8'h00);

    // enable, flag bit not writable
    wr(8'h02, 8'hC0);
    rd(8'h02, d); chk("R10 flag write ignored", d, 8'h80);

    // falling edge
    fb_in = 0; settle(4);
    chk("R7 fall sets flag", {7'b0, diag_n}, 8'h00);
    rd(8'h02, d); chk("R8 read flag", d, 8'hC0);
    chk("R8 cleared", {7'b0, diag_n}, 8'h01);
    rd(8'h02, d); chk("R8 second read", d, 8'h80);

    // rising edge
    fb_in = 1; settle(4);
    chk("R7 rise sets flag", {7'b0, diag_n}, 8'h00);
    rd(8'h02, d); chk("R8 read flag rise", d, 8'hC0);

    // edge and clearing read in the same cycle
    @(negedge clk); fb_in = 0;
    @(negedge clk);
    @(negedge clk); rd_en = 1; addr = 8'h02;
    @(negedge clk); rd_en = 0; d = rdata;
    chk("R8 collide read value", d, 8'h80);
    chk("R8 collide flag kept", {7'b0, diag_n}, 8'h00);
    rd(8'h02, d); chk("R8 collide then read", d, 8'hC0);

    settle(3);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule